// File: doc/BRIEF.md
# Timestamp Event Capture FIFO

This block records timing events in a 16-entry first-in first-out queue. Each event stores the 64-bit value of the free-running time input at the moment it is taken, together with a descriptor: the event kind, a port number, and for packet events the message type, sequence number and domain. Software reads the oldest entry through four read-only words and then removes it with a pop write.

Four kinds of source feed the queue. A register write requests a software push event. Eight external input pins are synchronised, and each one's rising edge becomes an event when its own enable bit is set. Transmit and receive strobes from the packet path bring their message metadata with them. When several sources fire in one cycle, all of them are stored in a fixed order. An event that finds no free slot is lost, and a sticky overflow flag records the loss. A level interrupt stays asserted while the queue holds an entry and the interrupt is enabled.

Top module: `ts_event_fifo`

## Requirements
- R1: After reset the queue is empty. Every readable word reads 0 and irq is low. While the queue is empty, the head words at offsets 6 to 9 read 0.
- R2: A write to offset 1 with bit 0 set stores an entry in the same clock edge. The entry takes time_now from that edge, event code 0 (push), and port, message type, sequence and domain all 0.
- R3: Bit 8+i of the control word at offset 0 enables input hw_pin[i]. A rising edge on an enabled pin, after a two-flop synchroniser, stores an entry with event code 3 and port i+1. The entry takes time_now from the edge at which the synchronised rise is seen. A pin that is disabled, or that is held high, adds no entry.
- R4: tx_strobe stores an entry with event code 5. rx_strobe stores an entry with event code 4. Each entry carries the message type, sequence, port and domain presented with its strobe.
- R5: The descriptor word at offset 7 holds the sequence in bits 15:0, the message type in 19:16, the event code in 23:20 and the port in 28:24. The domain word at offset 8 holds the domain in bits 7:0.
- R6: Offset 6 reads head time bits 31:0 and offset 9 reads time bits 63:32. A write to offset 5 with bit 0 set removes the head. A pop while the queue is empty has no effect.
- R7: Entries leave in arrival order. The queue holds at most 16 entries.
- R8: Events of one cycle are stored in this order: push, then pins 1 to 8 in ascending order, then transmit, then receive.
- R9: An event that arrives when no slot is free is dropped, and sticky bit 1 of the raw status word (offset 2) is set. A write to offset 2 with bit 1 set clears that bit. A new drop in the same cycle wins over the clear.
- R10: Raw status bit 0 is 1 when the queue is not empty. The masked status word (offset 3) bit 0 equals raw bit 0 AND interrupt-enable bit 0 (offset 4). irq equals the masked bit.
- R11: When a pop and an event share a cycle, free space is judged before the pop. A full queue therefore drops the event, and the pop still removes the old head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time value |
| hw_pin | input | 8 | External event pins, asynchronous |
| tx_strobe | input | 1 | Transmit event strobe |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence number |
| tx_domain | input | 8 | Transmit domain |
| tx_port | input | 5 | Transmit port number |
| rx_strobe | input | 1 | Receive event strobe |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence number |
| rx_domain | input | 8 | Receive domain |
| rx_port | input | 5 | Receive port number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
A wrong fill level shows at the ports in the cycle after the faulty edge. It appears as raw status bit 0 or irq disagreeing with the number of pushes and pops made, or as a missing or spurious overflow bit on the seventeenth event. A wrong read or write pointer stays hidden until the head is read, and then gives a time or descriptor word that belongs to another entry. The bench therefore drains every queue it fills and compares each head against the order it predicted. A priority or slot-allocation error in same-cycle writes shows up only when those entries are drained, as descriptors out of the expected order.

// File: rtl/ts_evt_pkg.sv
package ts_evt_pkg;
  localparam int STAMP_W    = 64;
  localparam int SEQ_W      = 16;
  localparam int MSG_W      = 4;
  localparam int CODE_W     = 4;
  localparam int PORT_W     = 5;
  localparam int DOM_W      = 8;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 4;
  localparam int PIN_EN_LSB = 8;

  typedef enum logic [CODE_W-1:0] {
    EVT_PUSH = 4'd0,
    EVT_ROLL = 4'd1,
    EVT_HALF = 4'd2,
    EVT_HWIN = 4'd3,
    EVT_RECV = 4'd4,
    EVT_XMIT = 4'd5,
    EVT_COMP = 4'd6,
    EVT_HOST = 4'd7
  } evt_code_e;

  typedef struct packed {
    logic [STAMP_W-1:0] stamp;
    logic [DOM_W-1:0]   domain;
    logic [PORT_W-1:0]  port;
    evt_code_e          code;
    logic [MSG_W-1:0]   msg;
    logic [SEQ_W-1:0]   seq;
  } evt_rec_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PUSH = 4'd1;
  localparam logic [ADDR_W-1:0] A_RAW  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_POP  = 4'd5;
  localparam logic [ADDR_W-1:0] A_TLO  = 4'd6;
  localparam logic [ADDR_W-1:0] A_DESC = 4'd7;
  localparam logic [ADDR_W-1:0] A_DOM  = 4'd8;
  localparam logic [ADDR_W-1:0] A_THI  = 4'd9;

  function automatic logic [REG_W-1:0] pack_desc(input evt_rec_t r);
    return {3'b000, r.port, r.code, r.msg, r.seq};
  endfunction
endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_nx;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ts_pin_capture.sv
module ts_pin_capture #(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] pin_en,
  output logic [N_PINS-1:0] pin_hit
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic [SYNC_STAGES:0] chain_q;
    logic [SYNC_STAGES:0] chain_nx;

    always_comb begin
      chain_nx = {chain_q[SYNC_STAGES-1:0], pin_in[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_nx;
    end

    assign pin_hit[i] = pin_en[i] & chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  end
endmodule

// File: rtl/ts_evt_store.sv
module ts_evt_store
  import ts_evt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int N_SRC = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         src_vld,
  input  evt_rec_t [N_SRC-1:0]     src_rec,
  input  logic                     pop_req,
  output evt_rec_t                 head_rec,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     drop_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [AW-1:0] wr_ptr, wr_nx, rd_ptr, rd_nx;
  logic [LW-1:0] level_nx, free, acc;
  logic [AW-1:0] idx;
  logic          pop_ok;
  logic [DEPTH-1:0] slot_we;
  evt_rec_t      slot_wd [DEPTH];
  evt_rec_t      mem     [DEPTH];

  always_comb begin
    free       = LW'(DEPTH) - level;
    acc        = '0;
    idx        = '0;
    drop_pulse = 1'b0;
    slot_we    = '0;
    for (int s = 0; s < DEPTH; s++) slot_wd[s] = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (src_vld[k]) begin
        if (acc < free) begin
          idx          = wr_ptr + AW'(acc);
          slot_we[idx] = 1'b1;
          slot_wd[idx] = src_rec[k];
          acc          = acc + 1'b1;
        end else begin
          drop_pulse = 1'b1;
        end
      end
    end
    pop_ok   = pop_req & (level != '0);
    level_nx = level + acc - {{(LW-1){1'b0}}, pop_ok};
    wr_nx    = wr_ptr + AW'(acc);
    rd_nx    = rd_ptr + {{(AW-1){1'b0}}, pop_ok};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_nx;
      rd_ptr <= rd_nx;
      level  <= level_nx;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (slot_we[s]) mem[s] <= slot_wd[s];
    end
  end

  always_comb begin
    head_rec = (level == '0) ? '0 : mem[rd_ptr];
  end
endmodule

// File: rtl/ts_reg_file.sv
module ts_reg_file
  import ts_evt_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  evt_rec_t          head_rec,
  input  logic              fifo_nonempty,
  input  logic              drop_pulse,
  output logic [N_PINS-1:0] pin_en,
  output logic              push_req,
  output logic              pop_req,
  output logic              ovf_flag,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [N_PINS-1:0] ctrl_q, ctrl_nx;
  logic              ien_q, ien_nx;
  logic              ovf_q, ovf_nx;
  logic              ovf_clr;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_comb begin
    push_req = reg_wr && (reg_addr == A_PUSH) && reg_wdata[0];
    pop_req  = reg_wr && (reg_addr == A_POP)  && reg_wdata[0];
    ovf_clr  = reg_wr && (reg_addr == A_RAW)  && reg_wdata[1];
    ctrl_nx  = (reg_wr && reg_addr == A_CTRL) ? reg_wdata[PIN_EN_LSB +: N_PINS] : ctrl_q;
    ien_nx   = (reg_wr && reg_addr == A_IEN)  ? reg_wdata[0] : ien_q;
    ovf_nx   = drop_pulse | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nx;
      ien_q  <= ien_nx;
      ovf_q  <= ovf_nx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[PIN_EN_LSB +: N_PINS] = ctrl_q;
      A_RAW:  reg_rdata[1:0] = {ovf_q, fifo_nonempty};
      A_MASK: reg_rdata[0]   = fifo_nonempty & ien_q;
      A_IEN:  reg_rdata[0]   = ien_q;
      A_TLO:  reg_rdata      = head_rec.stamp[REG_W-1:0];
      A_DESC: reg_rdata      = pack_desc(head_rec);
      A_DOM:  reg_rdata[DOM_W-1:0] = head_rec.domain;
      A_THI:  reg_rdata      = head_rec.stamp[STAMP_W-1:REG_W];
      default: reg_rdata     = '0;
    endcase
  end

  assign pin_en   = ctrl_q;
  assign ovf_flag = ovf_q;
  assign irq      = fifo_nonempty & ien_q;
endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo
  import ts_evt_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int N_PINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAMP_W-1:0] time_now,
  input  logic [N_PINS-1:0]  hw_pin,
  input  logic               tx_strobe,
  input  logic [MSG_W-1:0]   tx_msg,
  input  logic [SEQ_W-1:0]   tx_seq,
  input  logic [DOM_W-1:0]   tx_domain,
  input  logic [PORT_W-1:0]  tx_port,
  input  logic               rx_strobe,
  input  logic [MSG_W-1:0]   rx_msg,
  input  logic [SEQ_W-1:0]   rx_seq,
  input  logic [DOM_W-1:0]   rx_domain,
  input  logic [PORT_W-1:0]  rx_port,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq
);
  localparam int N_SRC = N_PINS + 3;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic                rst_core_n;
  logic [N_PINS-1:0]   pin_en, pin_hit;
  logic                push_req, pop_req, ovf_flag, drop_pulse;
  logic [N_SRC-1:0]    src_vld;
  evt_rec_t [N_SRC-1:0] src_rec;
  evt_rec_t            head_rec;
  logic [LW-1:0]       fill_level;

  ts_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_core_n)
  );

  ts_pin_capture #(.N_PINS(N_PINS), .SYNC_STAGES(2)) u_pins (
    .clk(clk), .rst_n(rst_core_n), .pin_in(hw_pin), .pin_en(pin_en), .pin_hit(pin_hit)
  );

  // Source slots in storage order: push, pins ascending, transmit, receive
  always_comb begin
    src_vld = {rx_strobe, tx_strobe, pin_hit, push_req};
    src_rec = '0;
    src_rec[0].stamp = time_now;
    src_rec[0].code  = EVT_PUSH;
    for (int i = 0; i < N_PINS; i++) begin
      src_rec[1+i].stamp = time_now;
      src_rec[1+i].code  = EVT_HWIN;
      src_rec[1+i].port  = PORT_W'(i + 1);
    end
    src_rec[N_PINS+1].stamp  = time_now;
    src_rec[N_PINS+1].code   = EVT_XMIT;
    src_rec[N_PINS+1].msg    = tx_msg;
    src_rec[N_PINS+1].seq    = tx_seq;
    src_rec[N_PINS+1].domain = tx_domain;
    src_rec[N_PINS+1].port   = tx_port;
    src_rec[N_PINS+2].stamp  = time_now;
    src_rec[N_PINS+2].code   = EVT_RECV;
    src_rec[N_PINS+2].msg    = rx_msg;
    src_rec[N_PINS+2].seq    = rx_seq;
    src_rec[N_PINS+2].domain = rx_domain;
    src_rec[N_PINS+2].port   = rx_port;
  end

  ts_evt_store #(.DEPTH(DEPTH), .N_SRC(N_SRC)) u_store (
    .clk(clk), .rst_n(rst_core_n), .src_vld(src_vld), .src_rec(src_rec),
    .pop_req(pop_req), .head_rec(head_rec), .level(fill_level), .drop_pulse(drop_pulse)
  );

  ts_reg_file #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .head_rec(head_rec), .fifo_nonempty(fill_level != '0),
    .drop_pulse(drop_pulse), .pin_en(pin_en), .push_req(push_req), .pop_req(pop_req),
    .ovf_flag(ovf_flag), .reg_rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/ts_event_fifo_chk.sv
module ts_event_fifo_chk
  import ts_evt_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int N_PINS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq,
  input logic                   reg_wr,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [REG_W-1:0]       reg_wdata,
  input logic [REG_W-1:0]       reg_rdata,
  input logic                   tx_strobe,
  input logic                   rx_strobe,
  input logic [N_PINS-1:0]      pin_hit,
  input logic [$clog2(DEPTH):0] level,
  input logic                   ovf_flag
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic wr_push, wr_pop, wr_clr, quiet, head_addr;
  logic unused_chk;

  assign unused_chk = ^reg_wdata;
  assign wr_push   = reg_wr && (reg_addr == A_PUSH) && reg_wdata[0];
  assign wr_pop    = reg_wr && (reg_addr == A_POP)  && reg_wdata[0];
  assign wr_clr    = reg_wr && (reg_addr == A_RAW)  && reg_wdata[1];
  assign quiet     = !tx_strobe && !rx_strobe && (pin_hit == '0);
  assign head_addr = (reg_addr >= A_TLO) && (reg_addr <= A_THI);

  // R10
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !irq);

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_push && quiet && level < LW'(DEPTH)) |=> (level == $past(level) + 1'b1));

  // R6
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pop && quiet && level != '0) |=> (level == $past(level) - 1'b1));

  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pop && quiet && level == '0) |=> (level == '0));

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !wr_clr) |=> ovf_flag);

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_push && level == LW'(DEPTH)) |=> ovf_flag);

  // R1
  head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && head_addr) |-> (reg_rdata == '0));
endmodule

bind ts_event_fifo ts_event_fifo_chk #(.DEPTH(DEPTH), .N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_strobe(tx_strobe),
  .rx_strobe(rx_strobe), .pin_hit(pin_hit), .level(fill_level), .ovf_flag(ovf_flag)
);

// File: tb/sim_ts_event_fifo.sv
`timescale 1ns/1ps
module sim_ts_event_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_now;
  logic [7:0]  hw_pin;
  logic        tx_strobe, rx_strobe;
  logic [3:0]  tx_msg, rx_msg;
  logic [15:0] tx_seq, rx_seq;
  logic [7:0]  tx_domain, rx_domain;
  logic [4:0]  tx_port, rx_port;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ts_event_fifo u0 (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .hw_pin(hw_pin),
    .tx_strobe(tx_strobe), .tx_msg(tx_msg), .tx_seq(tx_seq), .tx_domain(tx_domain), .tx_port(tx_port),
    .rx_strobe(rx_strobe), .rx_msg(rx_msg), .rx_seq(rx_seq), .rx_domain(rx_domain), .rx_port(rx_port),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, {32'h0, d}, {32'h0, exp});
  endtask

  function automatic logic [31:0] desc(input logic [4:0] p, input logic [3:0] c,
                                       input logic [3:0] m, input logic [15:0] s);
    return {3'b000, p, c, m, s};
  endfunction

  task automatic t_reset;
    chk("R1 raw", {63'h0, irq}, 64'h0);
    chk_rd("R1 ctrl", 4'd0, 32'h0);
    chk_rd("R1 raw status", 4'd2, 32'h0);
    chk_rd("R1 masked", 4'd3, 32'h0);
    chk_rd("R1 ien", 4'd4, 32'h0);
    chk_rd("R1 head lo", 4'd6, 32'h0);
    chk_rd("R1 head desc", 4'd7, 32'h0);
    chk_rd("R1 head hi", 4'd9, 32'h0);
  endtask

  task automatic t_push;
    time_now = 64'h1111_2222_3333_4444;
    wr(4'd4, 32'h1);
    wr(4'd1, 32'h1);
    time_now = 64'h0;
    chk_rd("R10 raw nonempty", 4'd2, 32'h1);
    chk_rd("R10 masked", 4'd3, 32'h1);
    chk("R10 irq high", {63'h0, irq}, 64'h1);
    chk_rd("R2 time lo", 4'd6, 32'h3333_4444);
    chk_rd("R6 time hi", 4'd9, 32'h1111_2222);
    chk_rd("R2 push desc", 4'd7, 32'h0);
    chk_rd("R2 push domain", 4'd8, 32'h0);
    wr(4'd5, 32'h1);
    chk_rd("R6 pop empties", 4'd2, 32'h0);
    chk("R10 irq low", {63'h0, irq}, 64'h0);
    // interrupt disabled: raw set, masked and irq clear
    wr(4'd4, 32'h0);
    wr(4'd1, 32'h1);
    chk_rd("R10 raw with ien off", 4'd2, 32'h1);
    chk_rd("R10 masked with ien off", 4'd3, 32'h0);
    chk("R10 irq off", {63'h0, irq}, 64'h0);
    wr(4'd5, 32'h1);
  endtask

  task automatic t_txrx;
    time_now = 64'hAAAA_0000_0000_0010;
    @(negedge clk);
    tx_strobe = 1'b1; tx_msg = 4'h3; tx_seq = 16'hBEEF; tx_domain = 8'h2A; tx_port = 5'd2;
    @(negedge clk);
    tx_strobe = 1'b0;
    time_now = 64'hAAAA_0000_0000_0020;
    rx_strobe = 1'b1; rx_msg = 4'hC; rx_seq = 16'h0102; rx_domain = 8'h81; rx_port = 5'h11;
    @(negedge clk);
    rx_strobe = 1'b0;
    chk_rd("R4 tx desc", 4'd7, desc(5'd2, 4'd5, 4'h3, 16'hBEEF));
    chk_rd("R5 tx domain", 4'd8, 32'h2A);
    chk_rd("R4 tx time", 4'd6, 32'h10);
    wr(4'd5, 32'h1);
    chk_rd("R7 rx second desc", 4'd7, desc(5'h11, 4'd4, 4'hC, 16'h0102));
    chk_rd("R5 rx domain", 4'd8, 32'h81);
    chk_rd("R4 rx time hi", 4'd9, 32'hAAAA_0000);
    wr(4'd5, 32'h1);
    chk_rd("R7 empty after drain", 4'd2, 32'h0);
  endtask

  task automatic t_hw;
    time_now = 64'h0000_0005_0000_0077;
    wr(4'd0, 32'h0000_0400);
    chk_rd("R3 ctrl readback", 4'd0, 32'h0000_0400);
    @(negedge clk);
    hw_pin[2] = 1'b1; hw_pin[0] = 1'b1;
    repeat (6) @(negedge clk);
    hw_pin = '0;
    repeat (3) @(negedge clk);
    chk_rd("R3 hw desc", 4'd7, desc(5'd3, 4'd3, 4'h0, 16'h0));
    chk_rd("R3 hw time", 4'd6, 32'h77);
    wr(4'd5, 32'h1);
    chk_rd("R3 one entry only", 4'd2, 32'h0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_prio;
    time_now = 64'h0000_0000_0000_0555;
    wr(4'd0, 32'h0000_8100);
    @(negedge clk);
    hw_pin[0] = 1'b1; hw_pin[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h1;
    tx_strobe = 1'b1; tx_msg = 4'h1; tx_seq = 16'h0010; tx_port = 5'd4; tx_domain = 8'h05;
    rx_strobe = 1'b1; rx_msg = 4'h2; rx_seq = 16'h0020; rx_port = 5'd6; rx_domain = 8'h06;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; tx_strobe = 1'b0; rx_strobe = 1'b0; hw_pin = '0;
    chk_rd("R8 first push", 4'd7, 32'h0);
    chk_rd("R8 shared time", 4'd6, 32'h555);
    wr(4'd5, 32'h1);
    chk_rd("R8 second pin1", 4'd7, desc(5'd1, 4'd3, 4'h0, 16'h0));
    wr(4'd5, 32'h1);
    chk_rd("R8 third pin8", 4'd7, desc(5'd8, 4'd3, 4'h0, 16'h0));
    wr(4'd5, 32'h1);
    chk_rd("R8 fourth tx", 4'd7, desc(5'd4, 4'd5, 4'h1, 16'h0010));
    wr(4'd5, 32'h1);
    chk_rd("R8 fifth rx", 4'd7, desc(5'd6, 4'd4, 4'h2, 16'h0020));
    chk_rd("R8 rx time", 4'd6, 32'h555);
    wr(4'd5, 32'h1);
    chk_rd("R8 drained", 4'd2, 32'h0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 16; i++) begin
      time_now = 64'(100 + i);
      wr(4'd1, 32'h1);
    end
    chk_rd("R7 sixteen fit", 4'd2, 32'h1);
    time_now = 64'd999;
    wr(4'd1, 32'h1);
    chk_rd("R9 overflow set", 4'd2, 32'h3);
    chk_rd("R9 head kept", 4'd6, 32'd100);
    wr(4'd2, 32'h2);
    chk_rd("R9 overflow cleared", 4'd2, 32'h1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h1;
    tx_strobe = 1'b1; tx_msg = 4'h7; tx_seq = 16'h7777; tx_port = 5'd1; tx_domain = 8'h0;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; tx_strobe = 1'b0;
    chk_rd("R11 drop with pop", 4'd2, 32'h3);
    for (int i = 1; i < 16; i++) begin
      chk_rd($sformatf("R7 order %0d", i), 4'd6, 32'(100 + i));
      chk_rd($sformatf("R11 no tx %0d", i), 4'd7, 32'h0);
      wr(4'd5, 32'h1);
    end
    chk_rd("R9 sticky after drain", 4'd2, 32'h2);
    wr(4'd2, 32'h2);
    chk_rd("R9 cleared when empty", 4'd2, 32'h0);
  endtask

  task automatic t_pop_empty;
    wr(4'd5, 32'h1);
    chk_rd("R6 pop empty stays empty", 4'd2, 32'h0);
    time_now = 64'h77;
    wr(4'd1, 32'h1);
    chk_rd("R6 after empty pop", 4'd6, 32'h77);
    chk_rd("R6 single entry", 4'd2, 32'h1);
    wr(4'd5, 32'h1);
    chk_rd("R6 empty again", 4'd2, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; time_now = '0; hw_pin = '0;
    tx_strobe = 0; tx_msg = 0; tx_seq = 0; tx_domain = 0; tx_port = 0;
    rx_strobe = 0; rx_msg = 0; rx_seq = 0; rx_domain = 0; rx_port = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_push;
    t_txrx;
    t_hw;
    t_prio;
    t_full;
    t_pop_empty;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule